// File: doc/BRIEF.md
# Audio Slot Mute Controller

This block sits between the slot-level data stream of a time-slotted serial audio port and the bit shifter. Each beat carries one slot's sample, its slot index and a flag that marks the first slot of a frame. When the port transmits, the block can silence outgoing frames. With one or two active slots it either replays what each slot carried in the previous frame or sends zero. With more than two slots it always sends zero. When the port receives, samples pass through unchanged. The block also counts consecutive all-zero frames and raises a sticky detection flag, with an optional interrupt, once a programmed count is reached.

The mute request is sampled on the frame-start beat, so a frame is never half muted. The replay/zero choice is captured when the block is enabled. Slot count is given as `num_slots_m1` (active slots minus one). A frame ends on the beat whose slot index equals `num_slots_m1`.

Two state machines drive the block. The transmit machine has states TX_PASS and TX_MUTE, with these transitions:
- PASS→MUTE: a frame-start beat arrives while transmitting with the mute request high.
- MUTE→PASS: a frame-start beat arrives without the mute request, or the block is disabled.

The receive detector has states DET_OFF, DET_COUNT and DET_FULL, with these transitions:
- OFF→COUNT: the detector is armed (enabled, receiving, threshold non-zero).
- COUNT→COUNT: a frame ends, either counting up or resetting to zero.
- COUNT→FULL: a mute frame brings the count to the threshold; this sets the flag.
- FULL→COUNT: a non-mute frame ends.
- Any state→OFF: the detector is disarmed.

Top module: `audio_mute_ctrl`

## Requirements
- R1: After reset, out_valid, mute_det and irq are 0.
- R2: An accepted beat (in_valid and enable high) gives out_valid high on the next cycle, with out_data carrying the result. With enable low, out_valid is 0 on the next cycle. An unmuted transmit beat passes in_data unchanged.
- R3: In transmit mode, with the mute active, num_slots_m1 ≤ 1 and the captured mute value 1, slots 0 and 1 carry the data they carried in the previous frame.
- R4: In transmit mode, with the mute active, num_slots_m1 ≤ 1 and the captured mute value 0, every slot carries zero.
- R5: In transmit mode, with the mute active and num_slots_m1 ≥ 2, every slot carries zero whatever mute_val is.
- R6: mute_val is captured on the cycle enable rises. Changes while enable stays high take effect only after the next rising edge of enable.
- R7: mute_req is sampled on the frame-start beat and holds for the whole frame. A change in the middle of a frame takes effect at the next frame start.
- R8: In receive mode (is_tx=0), in_data passes to out_data unchanged, and mute_req and mute_val have no effect.
- R9: In receive mode, a frame whose slots are all zero is a mute frame. The frame spans from the frame-start beat to the beat with in_slot = num_slots_m1. mute_det rises on the cycle after the last beat of the mute_thresh-th consecutive mute frame.
- R10: irq equals mute_det AND det_irq_en.
- R11: mute_det stays high until a det_clr pulse clears it. A set in the same cycle wins over the clear.
- R12: A frame with any non-zero slot resets the count to 0. Once at the threshold, the count stops, and further mute frames do not set the flag again.
- R13: mute_thresh = 0, transmit mode or enable low disables detection and clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; its rising edge captures mute_val |
| is_tx | input | 1 | 1 = transmit, 0 = receive |
| num_slots_m1 | input | SLOT_W | Active slots minus one |
| mute_req | input | 1 | Transmit mute request, sampled at frame start |
| mute_val | input | 1 | 1 = replay previous frame, 0 = send zero (one or two slots only) |
| mute_thresh | input | CNT_W | Consecutive mute frames needed to detect; 0 disables |
| det_irq_en | input | 1 | Interrupt enable for mute detection |
| det_clr | input | 1 | One-cycle clear of mute_det |
| in_valid | input | 1 | Beat valid |
| in_frame_start | input | 1 | Beat is the first slot of a frame |
| in_slot | input | SLOT_W | Slot index of the beat |
| in_data | input | DATA_W | Slot sample |
| out_valid | output | 1 | Output beat valid |
| out_data | output | DATA_W | Slot sample after mute processing |
| mute_det | output | 1 | Sticky mute-detected flag |
| irq | output | 1 | Mute-detect interrupt |

## Verification
A corrupted replay register appears on out_data in the first muted frame, on the beat for that slot, one cycle after the beat enters. A mute state latched at the wrong time gives a whole frame of wrong data, visible from its second beat. A wrong frame count only appears when mute_det rises one frame too early or too late. That is why the bench tracks the count every clock and checks the flag on the exact cycle after each frame's last beat.

// File: rtl/amc_pkg.sv
package amc_pkg;
    typedef enum logic {
        TX_PASS = 1'b0,
        TX_MUTE = 1'b1
    } tx_state_t;

    typedef enum logic [1:0] {
        DET_OFF   = 2'd0,
        DET_COUNT = 2'd1,
        DET_FULL  = 2'd2
    } det_state_t;
endpackage

// File: rtl/amc_tx_path.sv
module amc_tx_path
    import amc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              is_tx,
    input  logic [SLOT_W-1:0] num_slots_m1,
    input  logic              mute_req,
    input  logic              mute_val,
    input  logic              in_valid,
    input  logic              in_frame_start,
    input  logic [SLOT_W-1:0] in_slot,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int REPLAY_N = 2;
    localparam int IDX_W    = $clog2(REPLAY_N);

    tx_state_t                     tx_state, tx_state_nx;
    logic                          en_q;
    logic                          mval_q;
    logic [REPLAY_N-1:0][DATA_W-1:0] hist_q;

    logic              en_rise;
    logic              eff_mval;
    logic              fs_beat;
    logic              muting;
    logic              few_slots;
    logic              replay_hit;
    logic [DATA_W-1:0] sel_data;

    assign en_rise    = enable & ~en_q;
    assign eff_mval   = en_rise ? mute_val : mval_q;
    assign fs_beat    = in_valid & in_frame_start;
    assign few_slots  = (num_slots_m1 < SLOT_W'(REPLAY_N));
    assign replay_hit = (in_slot < SLOT_W'(REPLAY_N));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_state <= TX_PASS;
            en_q     <= 1'b0;
            mval_q   <= 1'b0;
        end else begin
            tx_state <= tx_state_nx;
            en_q     <= enable;
            if (en_rise) begin
                mval_q <= mute_val;
            end
        end
    end

    // next state
    always_comb begin
        tx_state_nx = tx_state;
        if (!enable) begin
            tx_state_nx = TX_PASS;
        end else if (fs_beat) begin
            unique case (tx_state)
                TX_PASS: tx_state_nx = (is_tx && mute_req) ? TX_MUTE : TX_PASS;
                TX_MUTE: tx_state_nx = (is_tx && mute_req) ? TX_MUTE : TX_PASS;
                default: tx_state_nx = TX_PASS;
            endcase
        end
    end

    // output selection
    always_comb begin
        if (fs_beat) begin
            muting = is_tx & mute_req;
        end else begin
            muting = is_tx & (tx_state == TX_MUTE);
        end
        sel_data = in_data;
        if (muting) begin
            if (few_slots && eff_mval && replay_hit) begin
                sel_data = hist_q[in_slot[IDX_W-1:0]];
            end else begin
                sel_data = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            hist_q    <= '0;
        end else begin
            out_valid <= in_valid & enable;
            if (in_valid && enable) begin
                out_data <= sel_data;
                for (int i = 0; i < REPLAY_N; i++) begin
                    if (is_tx && in_slot == SLOT_W'(i)) begin
                        hist_q[i] <= sel_data;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/amc_frame_scan.sv
module amc_frame_scan #(
    parameter int DATA_W = 16,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [SLOT_W-1:0] num_slots_m1,
    input  logic              in_valid,
    input  logic              in_frame_start,
    input  logic [SLOT_W-1:0] in_slot,
    input  logic [DATA_W-1:0] in_data,
    output logic              frame_end,
    output logic              frame_zero
);
    logic acc_zero_q;
    logic beat;
    logic zero_so_far;

    assign beat        = in_valid & enable;
    assign zero_so_far = (in_frame_start | acc_zero_q) & (in_data == '0);
    assign frame_end   = beat & (in_slot == num_slots_m1);
    assign frame_zero  = zero_so_far;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_zero_q <= 1'b0;
        end else if (beat) begin
            acc_zero_q <= zero_so_far;
        end
    end
endmodule

// File: rtl/amc_rx_detect.sv
module amc_rx_detect
    import amc_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             frame_end,
    input  logic             frame_zero,
    input  logic [CNT_W-1:0] thresh,
    input  logic             clr,
    output logic             flag
);
    det_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DET_OFF;
            cnt_q <= '0;
            flag  <= 1'b0;
        end else begin
            state <= state_nx;
            cnt_q <= cnt_nx;
            if (hit) begin
                flag <= 1'b1;
            end else if (clr) begin
                flag <= 1'b0;
            end
        end
    end

    // next state and count
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt_q;
        hit      = 1'b0;
        if (!armed) begin
            state_nx = DET_OFF;
            cnt_nx   = '0;
        end else begin
            unique case (state)
                DET_OFF, DET_COUNT: begin
                    state_nx = DET_COUNT;
                    if (frame_end) begin
                        if (!frame_zero) begin
                            cnt_nx = '0;
                        end else if (cnt_q + CNT_W'(1) == thresh) begin
                            state_nx = DET_FULL;
                            cnt_nx   = thresh;
                            hit      = 1'b1;
                        end else begin
                            cnt_nx = cnt_q + CNT_W'(1);
                        end
                    end
                end
                DET_FULL: begin
                    if (frame_end && !frame_zero) begin
                        state_nx = DET_COUNT;
                        cnt_nx   = '0;
                    end
                end
                default: begin
                    state_nx = DET_OFF;
                    cnt_nx   = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/audio_mute_ctrl.sv
module audio_mute_ctrl #(
    parameter int DATA_W = 16,
    parameter int SLOT_W = 4,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              is_tx,
    input  logic [SLOT_W-1:0] num_slots_m1,
    input  logic              mute_req,
    input  logic              mute_val,
    input  logic [CNT_W-1:0]  mute_thresh,
    input  logic              det_irq_en,
    input  logic              det_clr,
    input  logic              in_valid,
    input  logic              in_frame_start,
    input  logic [SLOT_W-1:0] in_slot,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              mute_det,
    output logic              irq
);
    logic frame_end;
    logic frame_zero;
    logic armed;

    assign armed = enable & ~is_tx & (mute_thresh != '0);

    amc_tx_path #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .is_tx(is_tx),
        .num_slots_m1(num_slots_m1), .mute_req(mute_req), .mute_val(mute_val),
        .in_valid(in_valid), .in_frame_start(in_frame_start), .in_slot(in_slot),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    amc_frame_scan #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .enable(enable), .num_slots_m1(num_slots_m1),
        .in_valid(in_valid), .in_frame_start(in_frame_start), .in_slot(in_slot),
        .in_data(in_data), .frame_end(frame_end), .frame_zero(frame_zero)
    );

    amc_rx_detect #(.CNT_W(CNT_W)) u_det (
        .clk(clk), .rst_n(rst_n), .armed(armed), .frame_end(frame_end),
        .frame_zero(frame_zero), .thresh(mute_thresh), .clr(det_clr),
        .flag(mute_det)
    );

    assign irq = mute_det & det_irq_en;
endmodule

// File: rtl/amc_checker.sv
module amc_checker #(
    parameter int DATA_W = 16,
    parameter int SLOT_W = 4,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              is_tx,
    input logic [SLOT_W-1:0] num_slots_m1,
    input logic              mute_req,
    input logic [CNT_W-1:0]  mute_thresh,
    input logic              det_clr,
    input logic              in_valid,
    input logic              in_frame_start,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              mute_det,
    input logic              irq
);
    // R2
    idle_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !out_valid);

    // R5
    many_slots_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && enable && is_tx && in_frame_start && mute_req &&
         num_slots_m1 > SLOT_W'(1)) |=> (out_valid && out_data == '0));

    // R8
    rx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && enable && !is_tx) |=> (out_data == $past(in_data)));

    // R10
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mute_det);

    // R11
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_det && !det_clr) |=> mute_det);

    // R13
    thresh_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_thresh == '0 && !mute_det) |=> !mute_det);
endmodule

bind audio_mute_ctrl amc_checker #(.DATA_W(DATA_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_amc_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .is_tx(is_tx),
    .num_slots_m1(num_slots_m1), .mute_req(mute_req), .mute_thresh(mute_thresh),
    .det_clr(det_clr), .in_valid(in_valid), .in_frame_start(in_frame_start),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .mute_det(mute_det), .irq(irq)
);

// File: tb/test_audio_mute_ctrl.sv
module test_audio_mute_ctrl;
    localparam int DATA_W = 16;
    localparam int SLOT_W = 4;
    localparam int CNT_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic              is_tx = 1'b1;
    logic [SLOT_W-1:0] num_slots_m1 = '0;
    logic              mute_req = 1'b0;
    logic              mute_val = 1'b0;
    logic [CNT_W-1:0]  mute_thresh = '0;
    logic              det_irq_en = 1'b0;
    logic              det_clr = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_frame_start = 1'b0;
    logic [SLOT_W-1:0] in_slot = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              mute_det;
    logic              irq;

    int checks = 0;
    int errors = 0;
    string cur_req = "R2";

    always #2 clk = ~clk;

    audio_mute_ctrl #(.DATA_W(DATA_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) i_audio_mute_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .is_tx(is_tx),
        .num_slots_m1(num_slots_m1), .mute_req(mute_req), .mute_val(mute_val),
        .mute_thresh(mute_thresh), .det_irq_en(det_irq_en), .det_clr(det_clr),
        .in_valid(in_valid), .in_frame_start(in_frame_start), .in_slot(in_slot),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
        .mute_det(mute_det), .irq(irq)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference model, advanced on every rising edge
    bit        m_valid, m_det, m_mute, m_mv, m_en_prev, m_acc, m_live;
    int        m_data, m_cnt;
    int        m_hist[2];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 0; m_det = 0; m_mute = 0; m_mv = 0; m_en_prev = 0;
            m_acc = 0; m_data = 0; m_cnt = 0; m_hist[0] = 0; m_hist[1] = 0;
            m_live = 1;
        end else begin
            bit mv_now, mut, fend, zero, hit;
            int od;
            mv_now = (enable && !m_en_prev) ? mute_val : m_mv;
            if (enable && !m_en_prev) m_mv = mute_val;
            m_en_prev = enable;
            mut = (in_valid && in_frame_start) ? (is_tx && mute_req) : (is_tx && m_mute);
            od = int'(in_data);
            if (mut) begin
                if (int'(num_slots_m1) + 1 <= 2 && mv_now && int'(in_slot) < 2) od = m_hist[in_slot];
                else od = 0;
            end
            zero = (in_frame_start || m_acc) && (in_data == 0);
            fend = enable && in_valid && (in_slot == num_slots_m1);
            hit = 0;
            if (!(enable && !is_tx && mute_thresh != 0)) m_cnt = 0;
            else if (fend) begin
                if (!zero) m_cnt = 0;
                else if (m_cnt < int'(mute_thresh)) begin
                    m_cnt++;
                    if (m_cnt == int'(mute_thresh)) hit = 1;
                end
            end
            if (hit) m_det = 1; else if (det_clr) m_det = 0;
            if (!enable) begin
                m_valid = 0; m_mute = 0;
            end else begin
                m_valid = in_valid;
                if (in_valid) begin
                    m_data = od;
                    m_acc = zero;
                    if (is_tx && int'(in_slot) < 2) m_hist[in_slot] = od;
                    if (in_frame_start) m_mute = is_tx && mute_req;
                end
            end
        end
    end

    // lockstep comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && m_live) begin
            check(cur_req, "model out_valid", out_valid, m_valid);
            if (m_valid) check(cur_req, "model out_data", out_data, m_data);
            check("R9", "model mute_det", mute_det, m_det);
            check("R10", "model irq", irq, m_det && det_irq_en);
        end
    end

    // one beat, then directed check of the result one cycle later
    task automatic beat(input bit fs, input int slot, input int data, input int exp, input string req);
        in_valid = 1; in_frame_start = fs; in_slot = SLOT_W'(slot); in_data = DATA_W'(data);
        @(negedge clk); #1;
        check(req, "out_data", out_data, exp);
        check(req, "out_valid", out_valid, 1);
    endtask

    task automatic idle(input int n);
        in_valid = 0; in_frame_start = 0;
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic zero_frames(input int n, input int slots);
        for (int f = 0; f < n; f++)
            for (int s = 0; s < slots; s++) beat(s == 0, s, 0, 0, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check("R1", "out_valid", out_valid, 0);
        check("R1", "mute_det", mute_det, 0);
        check("R1", "irq", irq, 0);
        rst_n = 1;
        @(negedge clk); #1;

        // transmit, two slots, replay captured
        is_tx = 1; num_slots_m1 = 1; mute_val = 1; enable = 1; cur_req = "R2";
        beat(1, 0, 'h1111, 'h1111, "R2");
        beat(0, 1, 'h2222, 'h2222, "R2");
        cur_req = "R3"; mute_req = 1;
        beat(1, 0, 'hAAAA, 'h1111, "R3");
        beat(0, 1, 'hBBBB, 'h2222, "R3");
        beat(1, 0, 'hCCCC, 'h1111, "R3");
        beat(0, 1, 'hDDDD, 'h2222, "R3");
        cur_req = "R6"; mute_val = 0;
        beat(1, 0, 'hEEEE, 'h1111, "R6");
        beat(0, 1, 'hFFFF, 'h2222, "R6");
        enable = 0; idle(1);
        check("R2", "out_valid while disabled", out_valid, 0);
        enable = 1; cur_req = "R4";
        beat(1, 0, 'h1234, 0, "R4");
        beat(0, 1, 'h5678, 0, "R4");
        mute_req = 0; cur_req = "R2";
        beat(1, 0, 'h3333, 'h3333, "R2");
        beat(0, 1, 'h4444, 'h4444, "R2");
        cur_req = "R7";
        beat(1, 0, 'h5555, 'h5555, "R7");
        mute_req = 1;
        beat(0, 1, 'h6666, 'h6666, "R7");
        beat(1, 0, 'h7777, 0, "R7");
        beat(0, 1, 'h8888, 0, "R7");

        // transmit, four slots
        enable = 0; mute_req = 0; idle(1);
        num_slots_m1 = 3; mute_val = 1; enable = 1; cur_req = "R5";
        for (int s = 0; s < 4; s++) beat(s == 0, s, s + 1, s + 1, "R2");
        mute_req = 1;
        for (int s = 0; s < 4; s++) beat(s == 0, s, 'h100 + s, 0, "R5");

        // receive
        enable = 0; idle(1);
        is_tx = 0; num_slots_m1 = 1; mute_thresh = 3; det_irq_en = 1; enable = 1;
        cur_req = "R8";
        beat(1, 0, 'h7777, 'h7777, "R8");
        beat(0, 1, 'h8888, 'h8888, "R8");
        zero_frames(2, 2);
        check("R9", "mute_det after 2 frames", mute_det, 0);
        zero_frames(1, 2);
        check("R9", "mute_det after 3 frames", mute_det, 1);
        check("R10", "irq enabled", irq, 1);
        det_irq_en = 0; idle(1);
        check("R10", "irq disabled", irq, 0);
        check("R11", "mute_det sticky", mute_det, 1);
        det_clr = 1; idle(1); det_clr = 0;
        check("R11", "mute_det cleared", mute_det, 0);
        zero_frames(1, 2);
        check("R12", "no re-set at threshold", mute_det, 0);
        beat(1, 0, 0, 0, "R12");
        beat(0, 1, 'h0001, 'h0001, "R12");
        zero_frames(2, 2);
        check("R12", "count reset by non-zero frame", mute_det, 0);
        zero_frames(1, 2);
        check("R12", "re-detect after reset", mute_det, 1);
        det_clr = 1; idle(1); det_clr = 0;
        mute_thresh = 0;
        zero_frames(5, 2);
        check("R13", "threshold zero", mute_det, 0);
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule